// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with Age-Based LRU

This block sits between a processor's load port and a slower word-wide memory. A byte address is split into tag, set index and byte offset. The tags of all four ways in the indexed set are compared at the same time. When one way matches, its word is steered to the output through a multiplexer selected by the one-hot match vector, in the same cycle the request is presented.

When no way matches, the requester is stalled and the block issues a word-aligned read to memory. The returned word is written, with its tag and a valid bit, into a victim way. The victim is chosen in this order: an empty way if the set has one, otherwise the least recently used way. One cycle after the memory data arrives, the block returns that word with hit asserted.

Recency is tracked per set as a 2-bit age for each way. A way that is touched, by a hit or by a fill, becomes age 0, and every way that was younger than it ages by one. Each block holds exactly one word. The set count is a parameter.

Top module: `quad_lru_cache`

## Requirements
- R1: The byte offset is address bits [1:0] and plays no part in lookup. The set index is bits [9:2] and the tag is bits [31:10]. An address that differs from a cached one only in bits [1:0] hits and returns the same word.
- R2: On a miss, `cpuStall` rises in the request cycle and `memRdReq` is raised on the next cycle. `memRdAddr` carries the request address with bits [1:0] cleared. In the cycle after `memRdValid`, the block gives `rspValid`=1, `rspHit`=1, `cpuStall`=0 and `rspData` equal to the fetched word.
- R3: On a hit, `rspValid` and `rspHit` are 1 and `rspData` holds the cached word, all in the request cycle, with `cpuStall`=0 and no memory read.
- R4: Four lines with different tags and the same index are all held at once, and each one hits afterwards.
- R5: A fill never evicts a valid line while the set still has an invalid way.
- R6: With the set full, a miss replaces the way used least recently. Both hits and fills count as uses.
- R7: After reset every way is invalid. While reset is applied, `rspValid`, `memRdReq` and `cpuStall` are 0.
- R8: Lines in different sets do not interact: the same tag under another index misses.
- R9: At most one way matches any lookup.
- R10: While a read is outstanding, `memRdReq` stays high and `memRdAddr` stays fixed until `memRdValid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Read request, held until rspValid |
| cpuAddr | input | 32 | Byte address of the request |
| cpuStall | output | 1 | Request pending on a miss |
| rspValid | output | 1 | Response word is valid this cycle |
| rspHit | output | 1 | Lookup matched a valid way |
| rspData | output | 32 | Returned word |
| memRdReq | output | 1 | Read request to lower memory |
| memRdAddr | output | 32 | Word-aligned read address |
| memRdValid | input | 1 | Lower memory data is valid |
| memRdData | input | 32 | Lower memory read word |

## Verification
The assertions rely on two things from the environment. First, the requester keeps `cpuReq` and `cpuAddr` steady from a miss until the response. Second, memory raises `memRdValid` only while `memRdReq` is high and for a single cycle per read. The stimulus follows both rules: it changes inputs only on falling edges, holds the address through every miss, and answers each read with exactly one valid pulse after a fixed delay. Recency order, eviction choice and tag width are then checked through miss and hit outcomes on one crowded set, with tags that use the highest address bits.

// File: rtl/quad_cache_pkg.sv
package quad_cache_pkg;

  // Strobes the control FSM hands to the datapath each cycle.
  typedef struct packed {
    logic capture;   // latch the request address on a miss
    logic useHeld;   // look up the latched address instead of cpuAddr
    logic fill;      // write the returned word into the victim way
    logic touch;     // mark the hit way most recently used
  } cacheStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } cacheState_t;

endpackage

// File: rtl/quad_cache_datapath.sv
module quad_cache_datapath
  import quad_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 256,
  parameter int WAYS     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  cacheStrobes_t              strb,
  input  logic [DATA_W-1:0]          fillData,
  output logic [WAYS-1:0]            hitVec,
  output logic                       hit,
  output logic [DATA_W-1:0]          rdData,
  output logic [ADDR_W-1:0]          heldAddr
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]   validArr [NUM_SETS];
  logic [TAG_W-1:0]  tagArr   [NUM_SETS][WAYS];
  logic [DATA_W-1:0] dataArr  [NUM_SETS][WAYS];
  logic [AGE_W-1:0]  ageArr   [NUM_SETS][WAYS];

  logic [ADDR_W-OFF_W-1:0] heldWord;
  logic [ADDR_W-OFF_W-1:0] lookWord;
  logic [SET_W-1:0]        lookSet;
  logic [TAG_W-1:0]        lookTag;
  logic [AGE_W-1:0]        hitIdx;
  logic [AGE_W-1:0]        victim;
  logic [AGE_W-1:0]        updWay;
  logic [AGE_W-1:0]        updAge;

  assign lookWord = strb.useHeld ? heldWord : cpuAddr[ADDR_W-1:OFF_W];
  assign lookSet  = lookWord[SET_W-1:0];
  assign lookTag  = lookWord[ADDR_W-OFF_W-1:SET_W];
  assign heldAddr = {heldWord, {OFF_W{1'b0}}};

  // Parallel tag compare, one comparator per way.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[lookSet][w] && (tagArr[lookSet][w] == lookTag);
  end
  assign hit = |hitVec;

  // AND-OR multiplexer steered by the one-hot match vector.
  always_comb begin
    rdData = '0;
    hitIdx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        rdData = rdData | dataArr[lookSet][w];
        hitIdx = hitIdx | AGE_W'(w);
      end
    end
  end

  // Victim: lowest invalid way first, else the oldest way.
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !validArr[lookSet][w]) begin
        victim = AGE_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ageArr[lookSet][w] == AGE_OLDEST) victim = AGE_W'(w);
      end
    end
  end

  assign updWay = strb.fill ? victim : hitIdx;
  assign updAge = ageArr[lookSet][updWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldWord <= '0;
    else if (strb.capture) heldWord <= cpuAddr[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validArr[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageArr[s][w] <= AGE_W'(w);
      end
    end else begin
      if (strb.fill) validArr[lookSet][victim] <= 1'b1;
      if (strb.fill || strb.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (AGE_W'(w) == updWay)
            ageArr[lookSet][w] <= '0;
          else if (ageArr[lookSet][w] < updAge)
            ageArr[lookSet][w] <= ageArr[lookSet][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill) begin
      tagArr[lookSet][victim]  <= lookTag;
      dataArr[lookSet][victim] <= fillData;
    end
  end

endmodule

// File: rtl/quad_cache_ctrl.sv
module quad_cache_ctrl
  import quad_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          hit,
  input  logic          memRdValid,
  output cacheStrobes_t strb,
  output logic          cpuStall,
  output logic          rspValid,
  output logic          memRdReq
);
  cacheState_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq && hit)  strb.touch = 1'b1;
        if (cpuReq && !hit) begin
          strb.capture = 1'b1;
          stateNxt     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strb.useHeld = 1'b1;
        if (memRdValid) begin
          strb.fill = 1'b1;
          stateNxt  = ST_DONE;
        end
      end
      ST_DONE: begin
        strb.useHeld = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign rspValid = ((state == ST_IDLE) && cpuReq && hit) || (state == ST_DONE);
  assign cpuStall = ((state == ST_IDLE) && cpuReq && !hit) || (state == ST_FETCH);
  assign memRdReq = (state == ST_FETCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/quad_lru_cache.sv
module quad_lru_cache
  import quad_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 256,
  parameter int WAYS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuStall,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData
);
  cacheStrobes_t   strb;
  logic [WAYS-1:0] hitVec;
  logic            hit;

  quad_cache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SETS(NUM_SETS), .WAYS(WAYS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .strb(strb),
    .fillData(memRdData), .hitVec(hitVec), .hit(hit),
    .rdData(rspData), .heldAddr(memRdAddr)
  );

  quad_cache_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .hit(hit),
    .memRdValid(memRdValid), .strb(strb), .cpuStall(cpuStall),
    .rspValid(rspValid), .memRdReq(memRdReq)
  );

  assign rspHit = hit;

endmodule

// File: rtl/quad_lru_cache_checker.sv
module quad_lru_cache_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuStall,
  input logic              rspValid,
  input logic              rspHit,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdValid,
  input logic [WAYS-1:0]   hitVec
);
  // R9: the way comparators never agree on two ways
  p_single_way_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R2: any response the block gives is a hit
  p_resp_is_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspHit);

  // R2: returned memory data produces a response on the next cycle
  p_fill_responds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdValid) |=> (rspValid && !cpuStall));

  // R2: a memory read only starts after a request that missed
  p_read_after_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdReq) |-> $past(cpuReq && !rspHit));

  // R10: an outstanding read keeps request and address steady
  p_read_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid) |=> (memRdReq && $stable(memRdAddr)));

  // R3: a response cycle never stalls or reads memory
  p_resp_no_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!cpuStall && !memRdReq));

endmodule

bind quad_lru_cache quad_lru_cache_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuStall(cpuStall),
  .rspValid(rspValid), .rspHit(rspHit), .memRdReq(memRdReq),
  .memRdAddr(memRdAddr), .memRdValid(memRdValid), .hitVec(hitVec)
);

// File: tb/quad_lru_cache_tb_top.sv
module quad_lru_cache_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        cpuStall, rspValid, rspHit, memRdReq;
  logic [31:0] rspData, memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  quad_lru_cache dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr),
    .cpuStall(cpuStall), .rspValid(rspValid), .rspHit(rspHit),
    .rspData(rspData), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData)
  );

  // Backing memory contents: a fixed scramble of the word address.
  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One read access; the expected outcome comes from the vector.
  task automatic doAccess(input logic [31:0] addr, input bit expMiss, input string req);
    logic [31:0] expData;
    expData = memWord(addr);
    @(negedge clk);
    cpuReq  = 1'b1;
    cpuAddr = addr;
    #1;
    if (!expMiss) begin
      check(rspValid && rspHit && !cpuStall && !memRdReq, req, "hit flags",
            {28'd0, rspValid, rspHit, cpuStall, memRdReq}, 32'hC);
      check(rspData == expData, req, "hit data", rspData, expData);
    end else begin
      check(!rspValid && cpuStall && !memRdReq, req, "miss stall",
            {29'd0, rspValid, cpuStall, memRdReq}, 32'h2);
      @(negedge clk); #1;
      check(memRdReq && memRdAddr == {addr[31:2], 2'b00}, req, "read address",
            memRdAddr, {addr[31:2], 2'b00});
      for (int i = 0; i < 2; i++) begin
        @(negedge clk); #1;
        check(memRdReq && cpuStall && memRdAddr == {addr[31:2], 2'b00},
              "R10", "read held", memRdAddr, {addr[31:2], 2'b00});
      end
      memRdValid = 1'b1;
      memRdData  = expData;
      @(negedge clk);
      memRdValid = 1'b0;
      memRdData  = '0;
      cpuReq     = 1'b0;
      #1;
      check(rspValid && rspHit && !cpuStall && !memRdReq, req, "fill response",
            {28'd0, rspValid, rspHit, cpuStall, memRdReq}, 32'hC);
      check(rspData == expData, req, "fill data", rspData, expData);
    end
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  // {requirement number, expect miss, address}; set 5 unless noted.
  // A=FFFFFC14 B=00000814 C=80000C14 D=00001014 E=00001414
  localparam int NVEC = 17;
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd5, 1'b1, 32'hFFFF_FC14},  // R5 A fills empty way
    {4'd5, 1'b1, 32'h0000_0814},  // R5 B
    {4'd5, 1'b1, 32'h8000_0C14},  // R5 C
    {4'd5, 1'b1, 32'h0000_1014},  // R5 D, set now full
    {4'd3, 1'b0, 32'hFFFF_FC14},  // R3 A hit
    {4'd4, 1'b0, 32'h0000_0814},  // R4 B still held
    {4'd6, 1'b1, 32'h0000_1414},  // R6 E evicts C
    {4'd4, 1'b0, 32'h0000_1014},  // R4 D hit
    {4'd6, 1'b1, 32'h8000_0C14},  // R6 C evicts A
    {4'd6, 1'b1, 32'hFFFF_FC14},  // R6 A evicts B
    {4'd3, 1'b0, 32'h0000_1414},  // R3 E hit
    {4'd6, 1'b1, 32'h0000_0814},  // R6 B evicts D
    {4'd1, 1'b0, 32'hFFFF_FC17},  // R1 offset ignored
    {4'd2, 1'b1, 32'h0000_1016},  // R2 aligned read, evicts C
    {4'd8, 1'b1, 32'hFFFF_FC18},  // R8 tag A in set 6
    {4'd6, 1'b0, 32'h0000_1414},  // R6 E survived
    {4'd6, 1'b1, 32'h8000_0C14}   // R6 C was evicted
  };

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R7: quiet outputs while reset is held
    check(!rspValid && !memRdReq && !cpuStall, "R7", "reset outputs",
          {29'd0, rspValid, memRdReq, cpuStall}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doAccess(VEC[i][31:0], VEC[i][32], $sformatf("R%0d", VEC[i][36:33]));
    end

    // R7: reset drops every line; a line present before now misses
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk); #1;
    check(!rspValid && !memRdReq && !cpuStall, "R7", "second reset outputs",
          {29'd0, rspValid, memRdReq, cpuStall}, 32'h0);
    rstN = 1'b1;
    doAccess(32'h0000_1414, 1'b1, "R7");
    // R3: hit right after its own refill
    doAccess(32'h0000_1414, 1'b0, "R3");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule